// File: doc/BRIEF.md
# Raster LCD Timing Generator

This block paces a non-interlaced LCD panel. It holds a pixel counter and a line counter, both advanced by a pixel-clock enable. From them it derives the horizontal and vertical sync pulses, a data-enable flag for the visible window, the position of the visible pixel, and a one-clock marker at the first visible pixel of each frame.

All geometry comes from two packed timing words. The bit fields in those words mix "value minus one" and plain encodings, and the line width is counted in blocks of sixteen pixels. A third word supplies the two sync polarity bits. A control word supplies the run bit and a dual-panel bit. In dual-panel mode the line field already holds the per-panel count, which is half the full display height. The generator therefore scans that many visible lines and nothing more.

Each line runs in this order: sync, back porch, visible pixels, front porch. Each frame runs in the same order, counted in lines.

Top module: `lcd_raster_timer`

## Requirements
- R1: The sync pulse width of a line is `horiz_word[15:8]`+1 pixel ticks, and sync starts each line. The back porch that follows lasts `horiz_word[31:24]`+1 ticks.
- R2: The visible part of a line is 16×(`horiz_word[7:2]`+1) pixels. A front porch of `horiz_word[23:16]`+1 ticks follows it. The pixel counter then wraps to the start of sync.
- R3: The vertical sync width is `vert_word[15:10]`+1 lines. The vertical back porch is `vert_word[31:24]` lines and the vertical front porch is `vert_word[23:16]` lines; neither porch is offset by one, and either may be zero. The number of visible lines is `vert_word[9:0]`+1.
- R4: `active` is high only when both the pixel counter and the line counter are inside their visible regions. While `active` is high, `x_pos` and `y_pos` give the visible column and row, counted from 0. While `active` is low, both are 0.
- R5: Setting `pol_word[12]` makes `hsync` active low, and setting `pol_word[11]` makes `vsync` active low. With the bit clear, the matching sync is active high.
- R6: While `ctrl_word[0]` is 0, both counters are cleared, both syncs sit at their inactive level, and `active`, `x_pos`, `y_pos` and `frame_start` are 0. When the bit is set again, scanning restarts at the first tick of line sync on line 0.
- R7: On a clock with `pix_ce` low the counters hold, so every output except `frame_start` keeps its value.
- R8: `frame_start` is high for exactly one clock. That clock is the one where `pix_ce` is high while the first visible pixel of the first visible line is shown.
- R9: The dual-panel bit `ctrl_word[7]` does not change the timing sequence. The line field is taken as the per-panel count in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel tick: the counters advance on clocks where it is high |
| horiz_word | input | 32 | Horizontal timing fields |
| vert_word | input | 32 | Vertical timing fields |
| pol_word | input | 32 | Sync polarity bits 12 (line) and 11 (frame) |
| ctrl_word | input | 32 | Bit 0 run, bit 7 dual panel |
| hsync | output | 1 | Line sync at the programmed polarity |
| vsync | output | 1 | Frame sync at the programmed polarity |
| active | output | 1 | Visible pixel flag |
| x_pos | output | X_W (10) | Visible column |
| y_pos | output | Y_W (10) | Visible row |
| frame_start | output | 1 | One-clock marker at the first visible pixel of a frame |

## Verification
The hardest situations to reach from the ports are the short vertical settings. These are zero-line porches, a one-line sync and a single visible line, where line wraps and frame wraps fall on the same tick. The longest sync widths are hard to reach for the same reason. Directed configurations pin these extremes. Seeded random configurations, with a random pixel-tick duty, interleave held clocks with advancing ones around every boundary. Each run ends with a mid-frame drop of the run bit, which exercises the clear and restart path from an arbitrary position.

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer #(
  parameter int HCNT_W = 12,
  parameter int VCNT_W = 11,
  parameter int X_W    = 10,
  parameter int Y_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic [31:0]       horiz_word,
  input  logic [31:0]       vert_word,
  input  logic [31:0]       pol_word,
  input  logic [31:0]       ctrl_word,
  output logic              hsync,
  output logic              vsync,
  output logic              active,
  output logic [X_W-1:0]    x_pos,
  output logic [Y_W-1:0]    y_pos,
  output logic              frame_start
);

  localparam logic [HCNT_W-1:0] H1  = HCNT_W'(1);
  localparam logic [HCNT_W-1:0] H16 = HCNT_W'(16);
  localparam logic [VCNT_W-1:0] V1  = VCNT_W'(1);

  logic en, inv_h, inv_v;
  assign en    = ctrl_word[0];
  assign inv_h = pol_word[12];
  assign inv_v = pol_word[11];

  logic unused_cfg;
  assign unused_cfg = ^{ctrl_word[31:1], pol_word[31:13], pol_word[10:0], horiz_word[1:0]};

  logic [HCNT_W-1:0] hsw, hbp, hfp, hppl, ha0, ha1, htot;
  assign hsw  = HCNT_W'(horiz_word[15:8])  + H1;
  assign hfp  = HCNT_W'(horiz_word[23:16]) + H1;
  assign hbp  = HCNT_W'(horiz_word[31:24]) + H1;
  assign hppl = HCNT_W'({horiz_word[7:2], 4'b0000}) + H16;
  assign ha0  = hsw + hbp;
  assign ha1  = ha0 + hppl;
  assign htot = ha1 + hfp;

  logic [VCNT_W-1:0] vsw, vbp, vfp, vlpp, va0, va1, vtot;
  assign vsw  = VCNT_W'(vert_word[15:10]) + V1;
  assign vfp  = VCNT_W'(vert_word[23:16]);
  assign vbp  = VCNT_W'(vert_word[31:24]);
  assign vlpp = VCNT_W'(vert_word[9:0]) + V1;
  assign va0  = vsw + vbp;
  assign va1  = va0 + vlpp;
  assign vtot = va1 + vfp;

  logic [HCNT_W-1:0] hcnt;
  logic [VCNT_W-1:0] vcnt;
  logic hlast, vlast;
  assign hlast = (hcnt == htot - H1);
  assign vlast = (vcnt == vtot - V1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (!en) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_ce) begin
      if (hlast) begin
        hcnt <= '0;
        vcnt <= vlast ? '0 : vcnt + V1;
      end else begin
        hcnt <= hcnt + H1;
      end
    end
  end

  logic h_vis, v_vis, hs_on, vs_on;
  assign h_vis = (hcnt >= ha0) && (hcnt < ha1);
  assign v_vis = (vcnt >= va0) && (vcnt < va1);
  assign hs_on = en && (hcnt < hsw);
  assign vs_on = en && (vcnt < vsw);

  assign hsync       = hs_on ^ inv_h;
  assign vsync       = vs_on ^ inv_v;
  assign active      = en && h_vis && v_vis;
  assign x_pos       = active ? X_W'(hcnt - ha0) : '0;
  assign y_pos       = active ? Y_W'(vcnt - va0) : '0;
  assign frame_start = pix_ce && active && (hcnt == ha0) && (vcnt == va0);

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (hcnt == '0 && vcnt == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pix_ce) |=> ($stable(hcnt) && $stable(vcnt)));

  p_fs_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pix_ce && hlast) |=> (hcnt == '0));

  p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (HCNT_W'(x_pos) < hppl && VCNT_W'(y_pos) < vlpp));

endmodule

// File: tb/lcd_raster_timer_tb_top.sv
`timescale 1ns/1ps
module lcd_raster_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n, pix_ce;
  logic [31:0] horiz_word, vert_word, pol_word, ctrl_word;
  logic hsync, vsync, active, frame_start;
  logic [9:0] x_pos, y_pos;

  always #2 clk = ~clk;

  lcd_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .horiz_word(horiz_word), .vert_word(vert_word),
    .pol_word(pol_word), .ctrl_word(ctrl_word),
    .hsync(hsync), .vsync(vsync), .active(active),
    .x_pos(x_pos), .y_pos(y_pos), .frame_start(frame_start)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int hsw_c, hbp_c, hfp_c, ppl_c, vsw_c, vbp_c, vfp_c, lpp_c;
  bit ih_c, iv_c, du_c;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int ppl_f, int hsw_f, int hfp_f, int hbp_f,
                         int lpp_f, int vsw_f, int vfp_f, int vbp_f,
                         bit ih, bit iv, bit du);
    horiz_word = {hbp_f[7:0], hfp_f[7:0], hsw_f[7:0], ppl_f[5:0], 2'b00};
    vert_word  = {vbp_f[7:0], vfp_f[7:0], vsw_f[5:0], lpp_f[9:0]};
    pol_word   = 32'h0;
    pol_word[12] = ih;
    pol_word[11] = iv;
    ctrl_word  = 32'h0;
    ctrl_word[7] = du;
    hsw_c = hsw_f + 1; hfp_c = hfp_f + 1; hbp_c = hbp_f + 1;
    ppl_c = (ppl_f + 1) * 16;
    vsw_c = vsw_f + 1; vfp_c = vfp_f; vbp_c = vbp_f; lpp_c = lpp_f + 1;
    ih_c = ih; iv_c = iv; du_c = du;
  endtask

  // expected outputs for tick index t since restart
  task automatic check_tick(int t, bit ce, bit prev_ce, bit first);
    int htot, vtot, h, v, e_x, e_y;
    bit hs, vs, ha, va, act, fs;
    htot = hsw_c + hbp_c + ppl_c + hfp_c;
    vtot = vsw_c + vbp_c + lpp_c + vfp_c;
    h = t % htot;
    v = (t / htot) % vtot;
    hs = h < hsw_c;
    vs = v < vsw_c;
    ha = (h >= hsw_c + hbp_c) && (h < hsw_c + hbp_c + ppl_c);
    va = (v >= vsw_c + vbp_c) && (v < vsw_c + vbp_c + lpp_c);
    act = ha && va;
    e_x = act ? h - hsw_c - hbp_c : 0;
    e_y = act ? v - vsw_c - vbp_c : 0;
    fs = ce && act && e_x == 0 && e_y == 0;
    chk(first ? "R6" : "R1", "hsync", int'(hsync), int'(hs ^ ih_c));
    chk(first ? "R6" : "R5", "vsync", int'(vsync), int'(vs ^ iv_c));
    chk(du_c ? "R9" : "R4", "active", int'(active), int'(act));
    chk(prev_ce ? "R2" : "R7", "x_pos", int'(x_pos), e_x);
    chk(du_c ? "R9" : "R3", "y_pos", int'(y_pos), e_y);
    chk("R8", "frame_start", int'(frame_start), int'(fs));
  endtask

  task automatic check_idle(int n);
    for (int i = 0; i < n; i++) begin
      pix_ce = ($urandom % 2) == 1;
      #1;
      chk("R6", "hsync idle", int'(hsync), int'(ih_c));
      chk("R6", "vsync idle", int'(vsync), int'(iv_c));
      chk("R6", "active idle", int'(active), 0);
      chk("R6", "x idle", int'(x_pos), 0);
      chk("R6", "y idle", int'(y_pos), 0);
      chk("R6", "fs idle", int'(frame_start), 0);
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(int frames, int ce_pct);
    int t, ncyc, htot, vtot;
    bit pce;
    htot = hsw_c + hbp_c + ppl_c + hfp_c;
    vtot = vsw_c + vbp_c + lpp_c + vfp_c;
    ncyc = (htot * vtot * frames * 100) / ce_pct + 20;
    check_idle(4);
    ctrl_word[0] = 1'b1;
    t = 0;
    pce = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      pix_ce = ($urandom % 100) < ce_pct;
      #1;
      check_tick(t, pix_ce, pce, i == 0);
      pce = pix_ce;
      if (pix_ce) t++;
      @(negedge clk);
    end
    ctrl_word[0] = 1'b0;
    check_idle(20);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pix_ce = 1'b0;
    set_cfg(0, 5, 5, 5, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check_idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // tight vertical: one-line sync, zero porches, single visible line
    run_cfg(3, 100);
    // wide syncs with both polarities inverted
    set_cfg(0, 255, 5, 5, 1, 31, 1, 1, 1, 1, 0);
    run_cfg(2, 50);
    for (int k = 0; k < 7; k++) begin
      set_cfg($urandom % 3, 5 + $urandom % 6, 5 + $urandom % 5, 5 + $urandom % 5,
              1 + $urandom % 5, $urandom % 4, $urandom % 4, $urandom % 4,
              $urandom % 2, $urandom % 2, $urandom % 2);
      run_cfg(2, 40 + $urandom % 61);
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not end actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule